// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits next to a prefetching processor and mirrors the processor's instruction queue, so that an attached coprocessor can tell whether a byte leaving the queue starts an instruction or continues one. It watches code-fetch bus cycles, appends each fetched byte to a six-entry shadow queue, and follows a 2-bit queue-status code from the processor. That code tells it to do nothing, to remove a byte that starts an opcode, to remove a byte that continues an instruction, or to discard everything held.

The processor reports each queue action one clock after it happened. The tracker therefore applies a status code to the queue as it stood before any byte that arrives in the same cycle. Removed bytes leave on a valid/ready stream, tagged with a first-byte flag. The processor cannot be stalled, so back-pressure cannot hold up the tracker. A removed byte stays on the stream until `byte_ready` accepts it. If a second byte is removed before that, the new byte replaces the old one and a sticky overrun flag is raised. Three sticky error flags record protocol breaks, and only reset clears them.

Top module: `instr_queue_tracker`

## Requirements
- R1: After reset the shadow queue is empty (`q_level` = 0), `byte_valid` is 0 and all three error flags are 0.
- R2: A code fetch opened by a `fetch_start` pulse and closed by a `fetch_end` pulse appends `fetch_data`, sampled in the `fetch_end` cycle, to the queue. A `fetch_end` with no open fetch has no effect.
- R3: Status code 2'b00 leaves the queue contents and `q_level` unchanged.
- R4: Status code 2'b01 removes the oldest byte. In the next cycle that byte is on `byte_data` with `byte_valid` = 1 and `byte_first` = 1.
- R5: Status code 2'b11 removes the oldest byte and presents it the same way as R4, but with `byte_first` = 0.
- R6: Status code 2'b10 discards every stored byte, so `q_level` reads 0 in the next cycle.
- R7: A flush also abandons any open fetch, and its later `fetch_end` pushes nothing. A `fetch_start` in the flush cycle opens a new fetch that does count.
- R8: A status code refers to the queue before that cycle's push. A removal in the cycle where a byte is pushed into an empty queue is an underflow, and the pushed byte stays in the queue.
- R9: A removal request while the queue is empty sets the sticky `err_underflow` flag and produces no output byte.
- R10: A push that would exceed six entries, counted after any same-cycle removal, is discarded and sets the sticky `err_overflow` flag.
- R11: `byte_valid` stays high with `byte_data` and `byte_first` held until `byte_ready` is high. A removal while an undelivered byte is held replaces it and sets the sticky `err_overrun` flag.
- R12: Bytes leave in the order they were fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_start | input | 1 | Pulse: a code-fetch bus cycle begins |
| fetch_end | input | 1 | Pulse: the open code fetch completes; data is on `fetch_data` |
| fetch_data | input | 8 | Data bus value at the end of a code fetch |
| q_status | input | 2 | Queue status from the processor, describing the previous cycle |
| byte_valid | output | 1 | A removed byte is presented |
| byte_ready | input | 1 | Consumer accepts the presented byte |
| byte_data | output | 8 | Removed byte |
| byte_first | output | 1 | 1 when the byte starts an opcode |
| q_level | output | 3 | Number of bytes in the shadow queue |
| err_underflow | output | 1 | Sticky: removal requested while empty |
| err_overflow | output | 1 | Sticky: push discarded because the queue was full |
| err_overrun | output | 1 | Sticky: an undelivered output byte was replaced |

## Verification
The bench targets the cycle where a removal and a push coincide. A design that applied the status code after the push would hand out the new byte and miss the underflow. It drives `fetch_end` after a flush with an abandoned fetch still open; a tracker that forgot the open fetch would push a stale byte into the emptied queue. The bench fills the queue to six bytes and pushes while removing, which shows whether the full test is taken before or after the removal. It also holds `byte_ready` low across back-to-back removals, where a wrong output stage would drop the newer byte or fail to flag the overrun.

// File: rtl/qt_pkg.sv
package qt_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_LATER = 2'b11
  } qs_code_e;

  typedef struct packed {
    logic take;
    logic first;
    logic flush;
  } qs_action_t;

endpackage

// File: rtl/qt_fetch_snoop.sv
module qt_fetch_snoop #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              fetch_end,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              flush,
  output logic              push,
  output logic [DATA_W-1:0] push_data
);

  logic open_q;
  logic open_d;

  always_comb begin
    if (flush) begin
      open_d = fetch_start;
    end else begin
      open_d = fetch_start | (open_q & ~fetch_end);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  assign push      = fetch_end & open_q & ~flush;
  assign push_data = fetch_data;

  AST_FLUSH_DROPS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fetch_start) |=> !push); // R7

endmodule

// File: rtl/qt_status_decode.sv
module qt_status_decode
  import qt_pkg::*;
(
  input  logic [1:0] q_status,
  output qs_action_t act
);

  qs_code_e code;

  always_comb begin
    code      = qs_code_e'(q_status);
    act.take  = 1'b0;
    act.first = 1'b0;
    act.flush = 1'b0;
    unique case (code)
      QS_IDLE:  ;
      QS_FIRST: begin act.take = 1'b1; act.first = 1'b1; end
      QS_FLUSH: act.flush = 1'b1;
      QS_LATER: act.take = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/qt_shadow_fifo.sv
module qt_shadow_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              take,
  input  logic              flush,
  output logic              take_ok,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic              err_underflow,
  output logic              err_overflow
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic [LVL_W-1:0]  count;
  logic [LVL_W-1:0]  after_take;
  logic              push_ok;
  logic              empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign empty      = (count == '0);
  assign take_ok    = take & ~empty & ~flush;
  assign after_take = count - LVL_W'(take_ok);
  assign push_ok    = push & ~flush & (after_take < LVL_W'(DEPTH));
  assign head_data  = slot_q[rd_ptr];
  assign level      = count;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (push_ok && wr_ptr == PTR_W'(i)) begin
        slot_q[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr        <= '0;
      wr_ptr        <= '0;
      count         <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (take_ok) rd_ptr <= bump(rd_ptr);
      if (push_ok) wr_ptr <= bump(wr_ptr);
      count <= after_take + LVL_W'(push_ok);
      if (take && empty) err_underflow <= 1'b1;
      if (push && !push_ok) err_overflow <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R6
  AST_EMPTY_TAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && empty) |=> err_underflow); // R9
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow); // R10

endmodule

// File: rtl/qt_out_stage.sv
module qt_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_first,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              first,
  output logic              err_overrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid       <= 1'b0;
      data        <= '0;
      first       <= 1'b0;
      err_overrun <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      first <= load_first;
      if (valid && !ready) err_overrun <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data) && $stable(first))); // R11
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> err_overrun); // R11

endmodule

// File: rtl/instr_queue_tracker.sv
module instr_queue_tracker
  import qt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              fetch_end,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic [1:0]        q_status,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_first,
  output logic [LVL_W-1:0]  q_level,
  output logic              err_underflow,
  output logic              err_overflow,
  output logic              err_overrun
);

  qs_action_t        act;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic              take_ok;
  logic [DATA_W-1:0] head_data;

  qt_status_decode u_decode (
    .q_status (q_status),
    .act      (act)
  );

  qt_fetch_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_start (fetch_start),
    .fetch_end   (fetch_end),
    .fetch_data  (fetch_data),
    .flush       (act.flush),
    .push        (push),
    .push_data   (push_data)
  );

  qt_shadow_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (push),
    .push_data     (push_data),
    .take          (act.take),
    .flush         (act.flush),
    .take_ok       (take_ok),
    .head_data     (head_data),
    .level         (q_level),
    .err_underflow (err_underflow),
    .err_overflow  (err_overflow)
  );

  qt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (take_ok),
    .load_data   (head_data),
    .load_first  (act.first),
    .ready       (byte_ready),
    .valid       (byte_valid),
    .data        (byte_data),
    .first       (byte_first),
    .err_overrun (err_overrun)
  );

  AST_IDLE_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status == 2'b00 && !fetch_end) |=> $stable(q_level)); // R3
  AST_FIRST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status == 2'b01 && q_level != '0) |=> (byte_valid && byte_first)); // R4
  AST_LATER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status == 2'b11 && q_level != '0) |=> (byte_valid && !byte_first)); // R5

endmodule

// File: tb/instr_queue_tracker_bench.sv
module instr_queue_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fetch_start, fetch_end, byte_ready;
  logic [7:0] fetch_data;
  logic [1:0] q_status;
  logic       byte_valid, byte_first, err_underflow, err_overflow, err_overrun;
  logic [7:0] byte_data;
  logic [2:0] q_level;

  always #5 clk = ~clk;

  instr_queue_tracker u_instr_queue_tracker (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .fetch_end(fetch_end),
    .fetch_data(fetch_data), .q_status(q_status), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .byte_first(byte_first),
    .q_level(q_level), .err_underflow(err_underflow), .err_overflow(err_overflow),
    .err_overrun(err_overrun)
  );

  int checks = 0;
  int fails  = 0;

  // reference state, built from the requirements
  logic [7:0] mq [8];
  int         mcnt;
  logic       mopen, mval, mfirst, meu, meo, mer;
  logic [7:0] mdata;
  logic [31:0] seed = 32'h1234_5679;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    mcnt = 0; mopen = 0; mval = 0; mfirst = 0; mdata = 0;
    meu = 0; meo = 0; mer = 0;
  endtask

  task automatic compare();
    check(byte_valid == mval, "R4 valid", int'(byte_valid), int'(mval));
    if (mval) begin
      check(byte_data == mdata, "R12 data", int'(byte_data), int'(mdata));
      check(byte_first == mfirst, "R5 first", int'(byte_first), int'(mfirst));
    end
    check(int'(q_level) == mcnt, "R2 level", int'(q_level), mcnt);
    check(err_underflow == meu, "R9 underflow", int'(err_underflow), int'(meu));
    check(err_overflow == meo, "R10 overflow", int'(err_overflow), int'(meo));
    check(err_overrun == mer, "R11 overrun", int'(err_overrun), int'(mer));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_start = 0; fetch_end = 0; fetch_data = 0;
    q_status = 0; byte_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
    #1 compare(); // R1
  endtask

  task automatic step(input logic s, input logic e, input logic [7:0] d,
                      input logic [1:0] q, input logic rdy);
    logic fl, tk, pu;
    @(negedge clk);
    fetch_start = s; fetch_end = e; fetch_data = d; q_status = q; byte_ready = rdy;
    @(posedge clk);
    fl = (q == 2'b10);
    tk = (q == 2'b01) || (q == 2'b11);
    pu = e && mopen && !fl;
    mopen = fl ? s : (s | (mopen & ~e));
    if (tk && mcnt > 0) begin
      if (mval && !rdy) mer = 1;
      mval = 1; mdata = mq[0]; mfirst = (q == 2'b01);
      for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
      mcnt--;
    end else if (rdy) begin
      mval = 0;
    end
    if (tk && mcnt == 0 && !(mval && mdata == mq[0] && 0)) begin
    end
    if (fl) mcnt = 0;
    if (pu) begin
      if (mcnt < 6) begin mq[mcnt] = d; mcnt++; end
      else meo = 1;
    end
    #1 compare();
  endtask

  // underflow depends on the pre-take level; tracked separately
  task automatic step_u(input logic s, input logic e, input logic [7:0] d,
                        input logic [1:0] q, input logic rdy);
    if (((q == 2'b01) || (q == 2'b11)) && mcnt == 0) meu = 1;
    step(s, e, d, q, rdy);
  endtask

  task automatic fetch(input logic [7:0] d);
    step_u(1, 0, 8'h00, 2'b00, 1);
    step_u(0, 1, d, 2'b00, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(); // R1

    // R2: a completed fetch pushes; a stray end pushes nothing
    fetch(8'hA1);
    step_u(0, 1, 8'hEE, 2'b00, 1);
    check(q_level == 3'd1, "R2 stray end", int'(q_level), 1);
    // R3: idle status keeps the level
    step_u(0, 0, 8'h00, 2'b00, 1);
    check(q_level == 3'd1, "R3 idle", int'(q_level), 1);
    // R4 and R12: first-byte removal
    fetch(8'hB2);
    step_u(0, 0, 8'h00, 2'b01, 0);
    check(byte_valid && byte_first && byte_data == 8'hA1, "R4 first", int'(byte_data), 'hA1);
    // R11: held while not ready, then a second removal overruns
    step_u(0, 0, 8'h00, 2'b00, 0);
    check(byte_data == 8'hA1 && byte_valid, "R11 hold", int'(byte_data), 'hA1);
    step_u(0, 0, 8'h00, 2'b11, 0);
    check(err_overrun && byte_data == 8'hB2 && !byte_first, "R5 later/R11 overrun",
          int'(byte_data), 'hB2);
    do_reset();

    // R6 and R7: flush with a fetch open, then its end arrives
    fetch(8'h11);
    step_u(1, 0, 8'h00, 2'b00, 1);
    step_u(0, 0, 8'h00, 2'b10, 1);
    check(q_level == 3'd0, "R6 flush", int'(q_level), 0);
    step_u(0, 1, 8'h22, 2'b00, 1);
    check(q_level == 3'd0, "R7 abandoned fetch", int'(q_level), 0);
    // R7: start in flush cycle counts
    step_u(1, 0, 8'h00, 2'b10, 1);
    step_u(0, 1, 8'h33, 2'b00, 1);
    check(q_level == 3'd1, "R7 new fetch", int'(q_level), 1);
    step_u(0, 0, 8'h00, 2'b11, 1);
    do_reset();

    // R8: removal in the cycle a byte enters an empty queue
    step_u(1, 0, 8'h00, 2'b00, 1);
    step_u(0, 1, 8'h44, 2'b01, 1);
    check(err_underflow && q_level == 3'd1 && !byte_valid, "R8 pre-push take",
          int'(q_level), 1);
    do_reset();

    // R10: fill to six, push while taking, then push while full
    for (int i = 0; i < 6; i++) fetch(8'h50 + 8'(i));
    step_u(1, 0, 8'h00, 2'b00, 1);
    step_u(0, 1, 8'h66, 2'b01, 1);
    check(q_level == 3'd6 && !err_overflow, "R10 take+push", int'(q_level), 6);
    fetch(8'h77);
    check(err_overflow && q_level == 3'd6, "R10 full", int'(err_overflow), 1);
    // R12: drain in order
    for (int i = 1; i < 6; i++) begin
      step_u(0, 0, 8'h00, 2'b11, 1);
      check(byte_data == 8'h50 + 8'(i), "R12 order", int'(byte_data), 'h50 + i);
    end
    step_u(0, 0, 8'h00, 2'b11, 1);
    check(byte_data == 8'h66, "R12 order tail", int'(byte_data), 'h66);
    // R9: take on empty
    step_u(0, 0, 8'h00, 2'b11, 1);
    check(err_underflow && !byte_valid, "R9 empty take", int'(err_underflow), 1);

    // sweep: pseudo-random sessions with varied take bias
    for (int sess = 0; sess < 12; sess++) begin
      do_reset();
      for (int c = 0; c < 600; c++) begin
        logic [1:0] q;
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
        q = (seed[7:4] < 4'(sess % 8 + 2)) ? ((seed[8]) ? 2'b01 : 2'b11)
          : ((seed[15:10] == 6'd0) ? 2'b10 : 2'b00);
        step_u(seed[16], seed[17], seed[31:24], q, seed[18] | seed[19]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule